// File: doc/BRIEF.md
# Shared Message-Bus Hold Arbiter

This block decides who drives a shared message-buffer and I/O bus: a DMA engine or the host processor. The DMA engine asks for the bus with a hold request and keeps it for as long as the acknowledge stays high. The processor raises a request whenever one of its cycles targets the shared bus, and pulses a done strobe when that cycle ends. The processor always has priority. A DMA engine that is active in the middle of a transfer loses its acknowledge, and the processor is granted only after the engine has let go of its request.

Every change of owner passes through a recovery gap. The gap is a parameterised number of clocks in which neither master is granted, so that the bus can settle and the previous owner's cycle can complete. A hold request that the DMA engine raises again while the processor owns the bus gets no answer until the processor signals done. The waiting engine is then served first. Two buffer enables, one for each side, follow the current owner.

Top module: `hold_arb`

## Requirements
- R1: After reset, dma_ack_o, cpu_gnt_o and both bits of buf_oe_o are 0.
- R2: When the bus is idle and dma_hold_i is high while cpu_req_i is low, dma_ack_o rises at the next clock edge. It then stays high for as long as dma_hold_i stays high and cpu_req_i stays low.
- R3: When cpu_req_i is high while the DMA engine is acknowledged and dma_hold_i is still high, dma_ack_o falls at the next edge. cpu_gnt_o stays low for as long as dma_hold_i stays high.
- R4: When the owner releases the bus, exactly RECOV_CYC clocks follow in which neither dma_ack_o nor cpu_gnt_o is high, and the next grant appears after them. The DMA engine releases by dropping dma_hold_i. The processor releases by pulsing cpu_done_i.
- R5: The processor has priority. If both requests are high on an idle bus, cpu_gnt_o is given. If both are pending at the end of a recovery gap that followed a DMA tenure, cpu_gnt_o is also given.
- R6: While cpu_gnt_o is high, raising dma_hold_i has no effect. cpu_gnt_o stays high and dma_ack_o stays low until cpu_done_i.
- R7: At the end of a recovery gap that followed a processor tenure, a pending dma_hold_i is acknowledged even if cpu_req_i is high again.
- R8: dma_ack_o and cpu_gnt_o are never high in the same cycle.
- R9: buf_oe_o bit 0 enables the DMA-side buffer and equals dma_ack_o. Bit 1 enables the processor-side buffer and equals cpu_gnt_o.
- R10: When the bus is idle and cpu_req_i is high, cpu_gnt_o rises at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_hold_i | input | 1 | Bus request from the DMA engine |
| dma_ack_o | output | 1 | Bus acknowledge to the DMA engine |
| cpu_req_i | input | 1 | Processor cycle targets the shared bus |
| cpu_done_i | input | 1 | Processor cycle on the shared bus has ended |
| cpu_gnt_o | output | 1 | Bus granted to the processor |
| buf_oe_o | output | 2 | Buffer enables: bit 0 DMA side, bit 1 processor side |

## Verification
The request from the processor and the hold request from the DMA engine can land in the same cycle. This happens on an idle bus, on the edge where the DMA engine drops its hold, and at the end of a processor tenure while a new processor request is already pending. The bench drives both inputs on the same clock in each of these three cases. It judges the outcome by which grant appears and by how many clocks pass before it does: the processor wins the first two cases, and the waiting DMA engine wins the third.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DMA   = 3'd1,
    ST_DRAIN = 3'd2,
    ST_RECOV = 3'd3,
    ST_CPU   = 3'd4
  } arb_state_e;

  localparam int unsigned NUM_MASTERS = 2;
  localparam int unsigned OWN_DMA = 0;
  localparam int unsigned OWN_CPU = 1;
endpackage

// File: rtl/hold_arb_timer.sv
module hold_arb_timer #(
  parameter int unsigned RECOV_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CW = (RECOV_CYC > 1) ? $clog2(RECOV_CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(RECOV_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/hold_arb_fsm.sv
module hold_arb_fsm
  import hold_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dma_hold_i,
  input  logic       cpu_req_i,
  input  logic       cpu_done_i,
  input  logic       tmr_expired_i,
  output logic       tmr_load_o,
  output arb_state_e state_o
);
  arb_state_e state_q, state_d;
  logic last_cpu_q, last_cpu_d;

  always_comb begin
    state_d    = state_q;
    last_cpu_d = last_cpu_q;
    tmr_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req_i)       state_d = ST_CPU;
        else if (dma_hold_i) state_d = ST_DMA;
      end
      ST_DMA: begin
        // release takes precedence over pre-emption: no drain needed
        if (!dma_hold_i) begin
          state_d = ST_RECOV; tmr_load_o = 1'b1; last_cpu_d = 1'b0;
        end else if (cpu_req_i) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!dma_hold_i) begin
          state_d = ST_RECOV; tmr_load_o = 1'b1; last_cpu_d = 1'b0;
        end
      end
      ST_CPU: begin
        if (cpu_done_i) begin
          state_d = ST_RECOV; tmr_load_o = 1'b1; last_cpu_d = 1'b1;
        end
      end
      ST_RECOV: begin
        if (tmr_expired_i) begin
          // a DMA engine held off by the processor is served first
          if (last_cpu_q && dma_hold_i) state_d = ST_DMA;
          else if (cpu_req_i)           state_d = ST_CPU;
          else if (dma_hold_i)          state_d = ST_DMA;
          else                          state_d = ST_IDLE;
          last_cpu_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      last_cpu_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      last_cpu_q <= last_cpu_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/hold_arb_steer.sv
module hold_arb_steer
  import hold_arb_pkg::*;
(
  input  arb_state_e             state_i,
  output logic [NUM_MASTERS-1:0] own_o
);
  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_own
    if (g == OWN_DMA) begin : g_dma
      assign own_o[g] = (state_i == ST_DMA);
    end else begin : g_cpu
      assign own_o[g] = (state_i == ST_CPU);
    end
  end
endmodule

// File: rtl/hold_arb.sv
module hold_arb
  import hold_arb_pkg::*;
#(
  parameter int unsigned RECOV_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dma_hold_i,
  output logic       dma_ack_o,
  input  logic       cpu_req_i,
  input  logic       cpu_done_i,
  output logic       cpu_gnt_o,
  output logic [1:0] buf_oe_o
);
  arb_state_e state;
  logic tmr_load, tmr_expired;
  logic [NUM_MASTERS-1:0] own;

  hold_arb_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dma_hold_i    (dma_hold_i),
    .cpu_req_i     (cpu_req_i),
    .cpu_done_i    (cpu_done_i),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .state_o       (state)
  );

  hold_arb_timer #(.RECOV_CYC(RECOV_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .expired_o (tmr_expired)
  );

  hold_arb_steer u_steer (
    .state_i (state),
    .own_o   (own)
  );

  assign dma_ack_o = own[OWN_DMA];
  assign cpu_gnt_o = own[OWN_CPU];
  assign buf_oe_o  = own;
endmodule

// File: rtl/hold_arb_chk.sv
module hold_arb_chk #(
  parameter int unsigned RECOV_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dma_hold_i,
  input logic       dma_ack_o,
  input logic       cpu_req_i,
  input logic       cpu_done_i,
  input logic       cpu_gnt_o,
  input logic [1:0] buf_oe_o
);
  localparam int unsigned GW = $clog2(RECOV_CYC + 1) + 1;
  logic [GW-1:0] gap_q;

  // idle clocks seen since the last owner, saturating at RECOV_CYC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       gap_q <= GW'(RECOV_CYC);
    else if (dma_ack_o || cpu_gnt_o)   gap_q <= '0;
    else if (gap_q < GW'(RECOV_CYC))   gap_q <= gap_q + 1'b1;
  end

  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dma_ack_o && cpu_gnt_o));

  a_r2_dma_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_o && dma_hold_i && !cpu_req_i) |=> dma_ack_o);

  a_r3_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_o && dma_hold_i && cpu_req_i) |=> !dma_ack_o);

  a_r3_no_direct_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_ack_o |=> !cpu_gnt_o);

  a_r6_cpu_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_gnt_o && !cpu_done_i) |=> cpu_gnt_o);

  a_r6_hold_withheld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_gnt_o |=> !dma_ack_o);

  a_r4_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dma_ack_o) || $rose(cpu_gnt_o)) |-> (gap_q >= GW'(RECOV_CYC)));

  a_r9_buf_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_oe_o[0] == dma_ack_o) && (buf_oe_o[1] == cpu_gnt_o));
endmodule

bind hold_arb hold_arb_chk #(.RECOV_CYC(RECOV_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dma_hold_i (dma_hold_i),
  .dma_ack_o  (dma_ack_o),
  .cpu_req_i  (cpu_req_i),
  .cpu_done_i (cpu_done_i),
  .cpu_gnt_o  (cpu_gnt_o),
  .buf_oe_o   (buf_oe_o)
);

// File: tb/hold_arb_bench.sv
`timescale 1ns/1ps
module hold_arb_bench;
  localparam int unsigned RECOV_CYC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b0, req = 1'b0, done = 1'b0;
  logic ack, gnt;
  logic [1:0] oe;
  int unsigned n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hold_arb #(.RECOV_CYC(RECOV_CYC)) u_hold_arb (
    .clk_i(clk), .rst_ni(rst_n), .dma_hold_i(hold), .dma_ack_o(ack),
    .cpu_req_i(req), .cpu_done_i(done), .cpu_gnt_o(gnt), .buf_oe_o(oe)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic owners(input string tag, input logic e_ack, input logic e_gnt);
    chk({tag, " ack"}, {1'b0, ack}, {1'b0, e_ack});
    chk({tag, " gnt"}, {1'b0, gnt}, {1'b0, e_gnt});
  endtask

  task automatic do_reset();
    hold = 0; req = 0; done = 0;
    rst_n = 0;
    tick(2);
    rst_n = 1;
    tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    owners("R1 reset", 1'b0, 1'b0);
    chk("R1 reset buf_oe", oe, 2'b00);
  endtask

  task automatic t_dma_own_release();
    do_reset();
    hold = 1; tick();
    owners("R2 dma granted", 1'b1, 1'b0);
    chk("R9 dma buffer", oe, 2'b01);
    tick(3);
    owners("R2 dma kept", 1'b1, 1'b0);
    hold = 0; tick();
    owners("R4 dma release", 1'b0, 1'b0);
    hold = 1;               // re-raised at once: must wait out the gap
    tick();
    owners("R4 gap clk2", 1'b0, 1'b0);
    tick();
    owners("R4 regrant after gap", 1'b1, 1'b0);
  endtask

  task automatic t_preempt();
    do_reset();
    hold = 1; tick();
    req = 1; tick();
    owners("R3 ack withdrawn", 1'b0, 1'b0);
    tick(3);
    owners("R3 wait for hold drop", 1'b0, 1'b0);
    hold = 0; tick();
    owners("R4 gap clk1", 1'b0, 1'b0);
    tick();
    owners("R4 gap clk2", 1'b0, 1'b0);
    tick();
    owners("R3 cpu granted", 1'b0, 1'b1);
    chk("R9 cpu buffer", oe, 2'b10);
  endtask

  task automatic t_cpu_then_dma();
    do_reset();
    req = 1; tick();
    owners("R10 cpu from idle", 1'b0, 1'b1);
    hold = 1; tick(3);
    owners("R6 hold ignored", 1'b0, 1'b1);
    chk("R6 buffers", oe, 2'b10);
    done = 1; req = 0; tick();
    owners("R4 cpu release", 1'b0, 1'b0);
    done = 0; req = 1;      // new cpu cycle races the waiting dma
    tick();
    owners("R4 gap clk2", 1'b0, 1'b0);
    tick();
    owners("R7 waiting dma served", 1'b1, 1'b0);
    tick();
    owners("R3 dma pre-empted again", 1'b0, 1'b0);
  endtask

  task automatic t_simultaneous();
    do_reset();
    hold = 1; req = 1; tick();
    owners("R5 both from idle", 1'b0, 1'b1);
    chk("R9 buffers", oe, 2'b10);
  endtask

  task automatic t_release_with_req();
    do_reset();
    hold = 1; tick();
    hold = 0; req = 1; tick();
    owners("R4 release same edge", 1'b0, 1'b0);
    hold = 1; tick();
    owners("R4 gap clk2", 1'b0, 1'b0);
    tick();
    owners("R5 cpu wins after dma tenure", 1'b0, 1'b1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_dma_own_release();
    t_preempt();
    t_cpu_then_dma();
    t_simultaneous();
    t_release_with_req();
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule